// File: doc/BRIEF.md
# Watchdog Interrupt and Reset Controller

This block is a watchdog timer. It counts slow ticks and, when a programmed number of ticks passes without a kick, it times out. A timeout can raise an interrupt request, pulse a system reset request, or do both in two stages. It is used next to a CPU core that kicks it from its main loop and takes the interrupt when the loop stops kicking.

An 8-bit control register sets the behaviour. It holds a timeout flag, an interrupt enable, a reset enable, a stored change-enable bit and a 4-bit length select. The interrupt request is the flag gated by the interrupt enable and a global interrupt enable input. An acknowledge input stands for the CPU taking the interrupt vector. In the combined mode the first timeout only interrupts. The acknowledge then drops the interrupt enable, so the next timeout resets the system.

Top module: `wdt_irqrst`

## Requirements
- R1: After reset the control register reads 0x00 and both `irqReq` and `sysRstReq` are low.
- R2: A write with `wrEn` stores `wrData[6:0]` into control bits 6:0, and `ctrlOut` reads them back. The fields are: bit 6 interrupt enable, bit 3 reset enable, bit 4 a stored bit with no effect, and bits {5,2,1,0} the length select with bit 5 as its MSB.
- R3: Bit 7 is the timeout flag. A write with `wrData[7]`=1 clears it and a write with `wrData[7]`=0 leaves it unchanged. A timeout that sets the flag in the same cycle wins.
- R4: `irqReq` is high exactly when the flag, bit 6 and `globalIe` are all 1.
- R5: The counter advances only on cycles with `tick` high. A timeout occurs on the 2^(BASE_EXP+s)-th tick after the counter was cleared, where s is the select value, and select values above 9 act as 9. The counter restarts after each timeout.
- R6: With bit 6 = 1 and bit 3 = 0, a timeout sets the flag and `sysRstReq` never rises.
- R7: With bit 3 = 1 and bit 6 = 0, a timeout drives `sysRstReq` high for exactly one cycle, in the cycle after the timeout tick, and does not set the flag.
- R8: With bits 6 and 3 both 1, the first timeout sets the flag only. An `irqAck` clears the flag and bit 6, which leaves reset-only mode, and the next timeout pulses `sysRstReq`.
- R9: In interrupt-only mode `irqAck` clears the flag and leaves bit 6 set.
- R10: A `kick` pulse, or any control write, restarts the timeout count from zero.
- R11: With bits 6 and 3 both 0 the watchdog is stopped, and neither the flag nor `sysRstReq` is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow time-base enable, one cycle per tick |
| kick | input | 1 | Restart the timeout count |
| globalIe | input | 1 | Global interrupt enable from the CPU |
| irqAck | input | 1 | Interrupt vector taken |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 8 | Control register write data |
| ctrlOut | output | 8 | Control register read value |
| irqReq | output | 1 | Interrupt request |
| sysRstReq | output | 1 | One-cycle system reset request |

## Verification
The bench targets the exact timeout length at the smallest select, at a middle value, and at a select above the clamp limit. A counter with an off-by-one error fires one cycle early or late. A design without the clamp would run on for far longer than 2^(BASE_EXP+9) ticks. The combined sequence checks that the acknowledge clears the interrupt enable, and a design that missed this would keep interrupting and never reset. The bench also checks that a write with a zero in bit 7 keeps a pending flag, and that kicks and writes restart the count. Long random runs with ticks, acknowledges, kicks and writes in any mix are compared against a cycle model in the bench. This catches wrong priorities when several events land in the same cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic clear;    // restart count from zero
    logic advance;  // one tick of count while running
  } cntStrb_t;

  // Operating mode, decoded from {reset enable, interrupt enable}
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_IRQ  = 2'b01,
    MODE_RST  = 2'b10,
    MODE_BOTH = 2'b11
  } mode_t;

  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int SELH_BIT = 5;
  localparam int CHG_BIT  = 4;
  localparam int RE_BIT   = 3;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int MAX_SEL  = 9,
  parameter int SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrb_t         strb,
  input  logic [SEL_W-1:0] selIn,
  output logic             hit
);

  localparam int CNT_W = BASE_EXP + MAX_SEL;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] termVal [0:MAX_SEL];
  logic [SEL_W-1:0] selEff;

  // Terminal count for each select value: all-ones of width BASE_EXP+g
  for (genvar g = 0; g <= MAX_SEL; g++) begin : gen_term
    assign termVal[g] = {CNT_W{1'b1}} >> (MAX_SEL - g);
  end

  always_comb begin
    selEff = (selIn > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : selIn;
    hit    = strb.advance && (cnt == termVal[selEff]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.clear || hit) begin
      cnt <= '0;
    end else if (strb.advance) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_WRAP_AFTER_HIT: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (cnt == '0)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.clear && !hit) |=> (cnt == $past(cnt) + 1'b1)); // R5
  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (cnt == '0)); // R10

endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             kick,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             irqAck,
  input  logic             hit,
  output cntStrb_t         strb,
  output logic [SEL_W-1:0] selOut,
  output logic [7:0]       ctrlQ,
  output logic             rstPulse
);

  logic             flagQ, ieQ, reQ, chgQ;
  logic [SEL_W-1:0] selQ;
  mode_t            mode;
  logic             flagSet, flagClr, rstFire, ackDropIe;

  always_comb begin
    mode          = mode_t'({reQ, ieQ});
    strb.clear    = wrEn || kick || (mode == MODE_OFF);
    strb.advance  = tick && (mode != MODE_OFF);
    flagSet       = hit && ieQ;
    flagClr       = irqAck || (wrEn && wrData[FLAG_BIT]);
    rstFire       = hit && (mode == MODE_RST);
    ackDropIe     = irqAck && (mode == MODE_BOTH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ    <= 1'b0;
      ieQ      <= 1'b0;
      reQ      <= 1'b0;
      chgQ     <= 1'b0;
      selQ     <= '0;
      rstPulse <= 1'b0;
    end else begin
      if (wrEn) begin
        ieQ  <= wrData[IE_BIT];
        reQ  <= wrData[RE_BIT];
        chgQ <= wrData[CHG_BIT];
        selQ <= SEL_W'({wrData[SELH_BIT], wrData[2:0]});
      end else if (ackDropIe) begin
        ieQ <= 1'b0;
      end
      if (flagSet) begin
        flagQ <= 1'b1;
      end else if (flagClr) begin
        flagQ <= 1'b0;
      end
      rstPulse <= rstFire;
    end
  end

  assign selOut = selQ;
  assign ctrlQ  = {flagQ, ieQ, selQ[3], chgQ, reQ, selQ[2:0]};

  AST_RST_NEEDS_IE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |-> !$past(ieQ)); // R6
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |=> !rstPulse); // R7
  AST_ACK_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !(hit && ieQ)) |=> !flagQ); // R9
  AST_COMBINED_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !wrEn && mode == MODE_BOTH) |=> (!ieQ && reQ)); // R8
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF && !wrEn) |=> (!rstPulse && !$rose(flagQ))); // R11

endmodule

// File: rtl/wdt_irqrst.sv
module wdt_irqrst
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int MAX_SEL  = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       kick,
  input  logic       globalIe,
  input  logic       irqAck,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] ctrlOut,
  output logic       irqReq,
  output logic       sysRstReq
);

  localparam int SEL_W = 4;

  cntStrb_t         strb;
  logic [SEL_W-1:0] sel;
  logic             hit;

  wdt_control #(.SEL_W(SEL_W)) u_control (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick),
    .wrEn(wrEn), .wrData(wrData), .irqAck(irqAck), .hit(hit),
    .strb(strb), .selOut(sel), .ctrlQ(ctrlOut), .rstPulse(sysRstReq)
  );

  wdt_datapath #(.BASE_EXP(BASE_EXP), .MAX_SEL(MAX_SEL), .SEL_W(SEL_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .selIn(sel), .hit(hit)
  );

  assign irqReq = ctrlOut[FLAG_BIT] && ctrlOut[IE_BIT] && globalIe;

  AST_RST_NOT_WITH_IRQ_MODE: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> !ctrlOut[FLAG_BIT] || $past(ctrlOut[FLAG_BIT])); // R7

endmodule

// File: tb/wdt_irqrst_bench.sv
module wdt_irqrst_bench;

  localparam int BASE = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic tick = 1'b0, kick = 1'b0, globalIe = 1'b0, irqAck = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] ctrlOut;
  logic irqReq, sysRstReq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_irqrst #(.BASE_EXP(BASE), .MAX_SEL(9)) u_wdt_irqrst (
    .clk(clk), .rstN(rstN), .tick(tick), .kick(kick), .globalIe(globalIe),
    .irqAck(irqAck), .wrEn(wrEn), .wrData(wrData),
    .ctrlOut(ctrlOut), .irqReq(irqReq), .sysRstReq(sysRstReq)
  );

  // ---- reference model built from the requirements ----
  function automatic int limitFor(logic [3:0] s);
    int e;
    e = (s > 4'd9) ? 9 : int'(s);
    return 1 << (BASE + e);
  endfunction

  logic       mFlag, mIe, mRe, mRst;
  logic [6:0] mCtrl;
  int         mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFlag = 0; mCtrl = '0; mCnt = 0; mRst = 0;
    end else begin
      logic run, hitM;
      mIe  = mCtrl[6];
      mRe  = mCtrl[3];
      run  = mIe || mRe;
      hitM = run && tick && (mCnt == limitFor({mCtrl[5], mCtrl[2:0]}) - 1);
      mRst = hitM && mRe && !mIe;
      if (hitM && mIe) mFlag = 1;
      else if (irqAck || (wrEn && wrData[7])) mFlag = 0;
      if (wrEn) mCtrl = wrData[6:0];
      else if (irqAck && mIe && mRe) mCtrl[6] = 1'b0;
      if (!run || kick || wrEn || hitM) mCnt = 0;
      else if (tick) mCnt = mCnt + 1;
    end
  end

  // ---- helpers ----
  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseAck();
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic pulseKick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // ---- watchdog ----
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---- stimulus ----
  initial begin
    int seen;
    void'($urandom(32'd20240611));
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    chk("R1", ctrlOut, 8'h00);
    chk("R1", {7'b0, irqReq}, 8'h00);
    chk("R1", {7'b0, sysRstReq}, 8'h00);

    tick = 1'b1; globalIe = 1'b1;
    wrReg(8'h17);
    chk("R2", ctrlOut, 8'h17);
    seen = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (sysRstReq || irqReq || ctrlOut[7]) seen++;
    end
    chk("R11", 8'(seen), 8'h00);
    chk("R11", ctrlOut, 8'h17);

    wrReg(8'h40);
    waitN(3); chk("R5", ctrlOut, 8'h40);
    waitN(1); chk("R6", ctrlOut, 8'hC0);
    chk("R4", {7'b0, irqReq}, 8'h01);
    globalIe = 1'b0;
    waitN(1); chk("R4", {7'b0, irqReq}, 8'h00);
    globalIe = 1'b1;

    wrReg(8'h40); chk("R3", ctrlOut, 8'hC0);
    wrReg(8'hC0); chk("R3", ctrlOut, 8'h40);
    tick = 1'b0;
    waitN(10); chk("R5", ctrlOut, 8'h40);
    tick = 1'b1;
    waitN(4); chk("R5", ctrlOut, 8'hC0);
    pulseAck(); chk("R9", ctrlOut, 8'h40);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sysRstReq) seen++;
    end
    chk("R6", 8'(seen), 8'h00);

    wrReg(8'hE7);
    waitN(2047); chk("R5", ctrlOut, 8'h67);
    waitN(1);    chk("R5", ctrlOut, 8'hE7);

    wrReg(8'hC1);
    waitN(6); pulseKick();
    waitN(7); chk("R10", ctrlOut, 8'h41);
    waitN(1); chk("R10", ctrlOut, 8'hC1);
    wrReg(8'hC1);
    waitN(6); wrReg(8'h41);
    waitN(7); chk("R10", ctrlOut, 8'h41);
    waitN(1); chk("R10", ctrlOut, 8'hC1);

    wrReg(8'h88);
    waitN(3); chk("R7", {7'b0, sysRstReq}, 8'h00);
    waitN(1); chk("R7", {7'b0, sysRstReq}, 8'h01);
    chk("R7", ctrlOut, 8'h08);
    waitN(1); chk("R7", {7'b0, sysRstReq}, 8'h00);

    wrReg(8'hC8);
    waitN(4); chk("R8", ctrlOut, 8'hC8);
    chk("R8", {7'b0, sysRstReq}, 8'h00);
    pulseAck(); chk("R8", ctrlOut, 8'h08);
    waitN(2); chk("R8", {7'b0, sysRstReq}, 8'h00);
    waitN(1); chk("R8", {7'b0, sysRstReq}, 8'h01);

    // random phase against the model
    for (int i = 0; i < 20000; i++) begin
      logic [7:0] d;
      @(negedge clk);
      chk("R2", ctrlOut, {mFlag, mCtrl});
      chk("R4", {7'b0, irqReq}, {7'b0, mFlag && mCtrl[6] && globalIe});
      chk("R7", {7'b0, sysRstReq}, {7'b0, mRst});
      d = 8'($urandom);
      d[5] = 1'b0; d[2:1] = 2'b00;
      tick     = ($urandom % 4) != 0;
      kick     = ($urandom % 50) == 0;
      irqAck   = ($urandom % 20) == 0;
      globalIe = ($urandom % 8) != 0;
      wrEn     = ($urandom % 100) == 0;
      wrData   = d;
    end
    @(negedge clk);
    wrEn = 1'b0; kick = 1'b0; irqAck = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule